// File: doc/BRIEF.md
# Display Shadow Register Update Controller

This block sits between software and a display scan-out engine. Software writes DMA and size parameters into a pending register bank, including the DMA enable. Those writes read back at once but leave the engine's active parameters untouched. An update is requested by setting an arm bit. At the next occurrence of a chosen point inside vertical blanking, the controller copies the pending bank into the active bank and clears the arm bit. Software polls that bit to learn that the new parameters are really in force.

The point in the frame is chosen by a 2-bit load-point field. It selects one of four places: front porch start, vsync start, back porch start, or the start of the last back porch line. The same point times a fetch-start pulse, which is issued every frame. It also times a FIFO-clear pulse, which is issued only when a load happens. No other path updates the active bank.

Top module: `shadow_update_ctrl`

## Requirements
- R1: After reset the active bank holds DMA disabled, base 0, width 0 and height 0. The arm bit reads 0, and `fetch_start_o` and `fifo_clr_o` are low.
- R2: Register map: address 0 is CTRL (bit 0 DMA enable, bits 9:8 load point, bit 12 arm), 1 is BASE (32 bits), 2 is SIZE (width in 15:0, height in 31:16) and 3 is VTIM (back porch line count in 7:0). A write is visible on `rd_data_o` the next cycle and does not change the active outputs by itself.
- R3: Writing CTRL with bit 12 set arms an update. Writing CTRL with bit 12 clear leaves the arm bit as it is. The arm bit reads 1 until the hardware clears it.
- R4: Load point 00 is the cycle in which `de_i` falls while `vblank_i` is high. An armed load copies the pending bank, so the active outputs show the new values on the next cycle, and the arm bit reads 0 from that cycle.
- R5: Load point 01 is the cycle in which `vsync_i` rises.
- R6: Load point 10 is the cycle in which `vsync_i` falls.
- R7: Load point 11 is the start of the last back porch line. The back porch counts VTIM lines, and its first line begins at the vsync falling edge. Later lines begin at `line_start_i` pulses. A VTIM value of 0 or 1 selects the vsync falling edge.
- R8: `fetch_start_o` is a one-cycle pulse in the cycle after every load point, armed or not. `fifo_clr_o` pulses in the same cycle only when a load takes place.
- R9: If the arm write arrives in the same cycle as the load point, the load still happens at that point. The arm bit then reads 1 for one cycle and 0 after that.
- R10: Writes to the pending bank are accepted while armed. A load copies the pending values including any write made in the load-point cycle.
- R11: The active outputs change only in a cycle in which `fifo_clr_o` is high. With no arm set, a whole frame leaves them unchanged. The load point is chosen from the pending CTRL and VTIM fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Pending register readback (CTRL includes arm bit) |
| de_i | input | 1 | Data enable from timing generator |
| vblank_i | input | 1 | Vertical blanking |
| vsync_i | input | 1 | Vertical sync |
| line_start_i | input | 1 | One-cycle pulse at each line start |
| act_dma_en_o | output | 1 | Active DMA enable |
| act_base_o | output | DATA_W | Active frame base address |
| act_width_o | output | DIM_W | Active width |
| act_height_o | output | DIM_W | Active height |
| fetch_start_o | output | 1 | Fetch-start pulse |
| fifo_clr_o | output | 1 | FIFO-clear pulse |

## Verification
Several behaviours are checked by assertions on every cycle. The active bank holds unless a FIFO-clear pulse occurs, and a FIFO-clear pulse always comes with a fetch-start pulse. The arm bit drops after a load and survives writes that leave bit 12 clear. Every load point falls inside blanking, and a same-cycle arm holds the bit for one cycle. Other behaviours need the bench's scenarios, which sweep all four load points over several back porch lengths in both armed and unarmed frames. These show that each load point sits exactly where it should in the frame and that the values loaded are the latest pending ones.

// File: rtl/shadow_upd_pkg.sv
package shadow_upd_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_BASE = 2'd1;
  localparam logic [1:0] A_SIZE = 2'd2;
  localparam logic [1:0] A_VTIM = 2'd3;
  localparam int EN_BIT  = 0;
  localparam int PT_LSB  = 8;
  localparam int ARM_BIT = 12;

  typedef enum logic [1:0] {
    PT_FP_START = 2'b00,
    PT_VS_START = 2'b01,
    PT_BP_START = 2'b10,
    PT_LAST_BP  = 2'b11
  } load_pt_e;
endpackage

// File: rtl/shadow_pending_regs.sv
module shadow_pending_regs
  import shadow_upd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16,
  parameter int VBP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              hit_i,
  output logic              load_o,
  output load_pt_e          pt_o,
  output logic [VBP_W-1:0]  vbp_o,
  output logic              nxt_en_o,
  output logic [DATA_W-1:0] nxt_base_o,
  output logic [DIM_W-1:0]  nxt_width_o,
  output logic [DIM_W-1:0]  nxt_height_o
);
  logic              en_q, arm_q, clr_pend_q, arm_d, clr_pend_d;
  load_pt_e          pt_q;
  logic [DATA_W-1:0] base_q;
  logic [DIM_W-1:0]  width_q, height_q;
  logic [VBP_W-1:0]  vbp_q;
  logic wr_ctrl, wr_base, wr_size, wr_vtim, wr_arm;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_base = wr_en_i && (wr_addr_i == A_BASE);
  assign wr_size = wr_en_i && (wr_addr_i == A_SIZE);
  assign wr_vtim = wr_en_i && (wr_addr_i == A_VTIM);
  assign wr_arm  = wr_ctrl && wr_data_i[ARM_BIT];

  // next pending values feed the load so a same-cycle write is captured
  assign nxt_en_o     = wr_ctrl ? wr_data_i[EN_BIT] : en_q;
  assign nxt_base_o   = wr_base ? wr_data_i : base_q;
  assign nxt_width_o  = wr_size ? wr_data_i[DIM_W-1:0] : width_q;
  assign nxt_height_o = wr_size ? wr_data_i[DIM_W +: DIM_W] : height_q;

  assign load_o = hit_i && (arm_q || wr_arm);
  assign pt_o   = pt_q;
  assign vbp_o  = vbp_q;

  always_comb begin
    arm_d      = arm_q | wr_arm;
    clr_pend_d = 1'b0;
    if (load_o) begin
      arm_d      = ~arm_q;   // same-cycle request: show armed for one cycle
      clr_pend_d = ~arm_q;
    end else if (clr_pend_q) begin
      arm_d = wr_arm;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      pt_q       <= PT_FP_START;
      base_q     <= '0;
      width_q    <= '0;
      height_q   <= '0;
      vbp_q      <= '0;
      arm_q      <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      en_q       <= nxt_en_o;
      base_q     <= nxt_base_o;
      width_q    <= nxt_width_o;
      height_q   <= nxt_height_o;
      arm_q      <= arm_d;
      clr_pend_q <= clr_pend_d;
      if (wr_ctrl) pt_q  <= load_pt_e'(wr_data_i[PT_LSB +: 2]);
      if (wr_vtim) vbp_q <= wr_data_i[VBP_W-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[EN_BIT]        = en_q;
        rd_data_o[PT_LSB +: 2]   = pt_q;
        rd_data_o[ARM_BIT]       = arm_q;
      end
      A_BASE: rd_data_o = base_q;
      A_SIZE: rd_data_o = {height_q, width_q};
      default: rd_data_o[VBP_W-1:0] = vbp_q;
    endcase
  end

  a_r4_arm_clears_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && arm_q) |=> !arm_q);
  a_r9_same_cycle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !arm_q) |=> (arm_q ##1 !arm_q));
  a_r3_zero_write_keeps_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && !load_o && !clr_pend_q) |=> arm_q);
endmodule

// File: rtl/load_point_sel.sv
module load_point_sel
  import shadow_upd_pkg::*;
#(
  parameter int VBP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             de_i,
  input  logic             vblank_i,
  input  logic             vsync_i,
  input  logic             line_start_i,
  input  load_pt_e         pt_i,
  input  logic [VBP_W-1:0] vbp_i,
  output logic             hit_o
);
  localparam int CW = VBP_W + 1;

  logic de_q, vb_q, vs_q, bp_act_q;
  logic [VBP_W-1:0] bp_cnt_q;
  logic de_fall, vs_rise, vs_fall, vb_fall, last_bp_line;
  logic [CW-1:0] cnt_nxt, last_idx;

  assign de_fall = de_q && !de_i;
  assign vs_rise = !vs_q && vsync_i;
  assign vs_fall = vs_q && !vsync_i;
  assign vb_fall = vb_q && !vblank_i;

  assign cnt_nxt  = CW'(bp_cnt_q) + CW'(1);
  assign last_idx = CW'(vbp_i) - CW'(1);

  always_comb begin
    if (vbp_i <= VBP_W'(1)) last_bp_line = vs_fall;
    else last_bp_line = !vs_fall && line_start_i && bp_act_q && (cnt_nxt == last_idx);
  end

  always_comb begin
    unique case (pt_i)
      PT_FP_START: hit_o = de_fall && vblank_i;
      PT_VS_START: hit_o = vs_rise;
      PT_BP_START: hit_o = vs_fall;
      default:     hit_o = last_bp_line;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q     <= 1'b0;
      vb_q     <= 1'b0;
      vs_q     <= 1'b0;
      bp_act_q <= 1'b0;
      bp_cnt_q <= '0;
    end else begin
      de_q <= de_i;
      vb_q <= vblank_i;
      vs_q <= vsync_i;
      if (vs_fall) begin
        bp_act_q <= 1'b1;
        bp_cnt_q <= '0;
      end else if (vb_fall || vs_rise) begin
        bp_act_q <= 1'b0;
      end else if (bp_act_q && line_start_i && (bp_cnt_q != '1)) begin
        bp_cnt_q <= bp_cnt_q + VBP_W'(1);
      end
    end
  end

  a_r6_hit_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> vblank_i);
endmodule

// File: rtl/active_bank.sv
module active_bank #(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              load_i,
  input  logic              nxt_en_i,
  input  logic [DATA_W-1:0] nxt_base_i,
  input  logic [DIM_W-1:0]  nxt_width_i,
  input  logic [DIM_W-1:0]  nxt_height_i,
  output logic              act_en_o,
  output logic [DATA_W-1:0] act_base_o,
  output logic [DIM_W-1:0]  act_width_o,
  output logic [DIM_W-1:0]  act_height_o,
  output logic              fetch_start_o,
  output logic              fifo_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_o      <= 1'b0;
      act_base_o    <= '0;
      act_width_o   <= '0;
      act_height_o  <= '0;
      fetch_start_o <= 1'b0;
      fifo_clr_o    <= 1'b0;
    end else begin
      fetch_start_o <= hit_i;
      fifo_clr_o    <= load_i;
      if (load_i) begin
        act_en_o     <= nxt_en_i;
        act_base_o   <= nxt_base_i;
        act_width_o  <= nxt_width_i;
        act_height_o <= nxt_height_i;
      end
    end
  end

  a_r8_clr_with_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |-> fetch_start_o);
  a_r11_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_clr_o |-> ($stable(act_en_o) && $stable(act_base_o) &&
                     $stable(act_width_o) && $stable(act_height_o)));
endmodule

// File: rtl/shadow_update_ctrl.sv
module shadow_update_ctrl
  import shadow_upd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16,
  parameter int VBP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              de_i,
  input  logic              vblank_i,
  input  logic              vsync_i,
  input  logic              line_start_i,
  output logic              act_dma_en_o,
  output logic [DATA_W-1:0] act_base_o,
  output logic [DIM_W-1:0]  act_width_o,
  output logic [DIM_W-1:0]  act_height_o,
  output logic              fetch_start_o,
  output logic              fifo_clr_o
);
  logic              hit, load, nxt_en;
  load_pt_e          pt;
  logic [VBP_W-1:0]  vbp;
  logic [DATA_W-1:0] nxt_base;
  logic [DIM_W-1:0]  nxt_width, nxt_height;

  shadow_pending_regs #(.DATA_W(DATA_W), .DIM_W(DIM_W), .VBP_W(VBP_W)) i_pend (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .hit_i(hit), .load_o(load), .pt_o(pt), .vbp_o(vbp),
    .nxt_en_o(nxt_en), .nxt_base_o(nxt_base),
    .nxt_width_o(nxt_width), .nxt_height_o(nxt_height)
  );

  load_point_sel #(.VBP_W(VBP_W)) i_sel (
    .clk_i, .rst_ni, .de_i, .vblank_i, .vsync_i, .line_start_i,
    .pt_i(pt), .vbp_i(vbp), .hit_o(hit)
  );

  active_bank #(.DATA_W(DATA_W), .DIM_W(DIM_W)) i_act (
    .clk_i, .rst_ni, .hit_i(hit), .load_i(load),
    .nxt_en_i(nxt_en), .nxt_base_i(nxt_base),
    .nxt_width_i(nxt_width), .nxt_height_i(nxt_height),
    .act_en_o(act_dma_en_o), .act_base_o, .act_width_o, .act_height_o,
    .fetch_start_o, .fifo_clr_o
  );
endmodule

// File: tb/test_shadow_update_ctrl.sv
module test_shadow_update_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, de = 1'b0, vb = 1'b0, vs = 1'b0, ls = 1'b0;
  logic [1:0] wa = '0, ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd, a_base;
  logic [15:0] a_w, a_h;
  logic a_en, fs, fc;

  int checks = 0, fails = 0;
  logic m_en = 0, m_arm = 0, m_clr = 0;
  logic [1:0] m_opt = 0;
  logic [31:0] m_base = 0;
  logic [15:0] m_w = 0, m_h = 0;
  logic [7:0] m_vbp = 0;
  logic e_en = 0;
  logic [31:0] e_base = 0;
  logic [15:0] e_w = 0, e_h = 0;
  string pt_tag [4] = '{"R4", "R5", "R6", "R7"};

  always #(CLK_P/2) clk = ~clk;

  shadow_update_ctrl i_shadow_update_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .de_i(de), .vblank_i(vb), .vsync_i(vs),
    .line_start_i(ls), .act_dma_en_o(a_en), .act_base_o(a_base),
    .act_width_o(a_w), .act_height_o(a_h), .fetch_start_o(fs), .fifo_clr_o(fc)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic i_de, i_vb, i_vs, i_ls, hit, input logic i_we,
                      input logic [1:0] i_wa, input logic [31:0] i_wd, input string tag);
    logic wr_arm, ld;
    @(negedge clk);
    de = i_de; vb = i_vb; vs = i_vs; ls = i_ls; we = i_we; wa = i_wa; wd = i_wd;
    @(posedge clk); #1;
    wr_arm = i_we && i_wa == 2'd0 && i_wd[12];
    ld = hit && (m_arm || wr_arm);
    if (i_we) case (i_wa)
      2'd0: begin m_en = i_wd[0]; m_opt = i_wd[9:8]; end
      2'd1: m_base = i_wd;
      2'd2: begin m_w = i_wd[15:0]; m_h = i_wd[31:16]; end
      default: m_vbp = i_wd[7:0];
    endcase
    if (ld) begin
      e_en = m_en; e_base = m_base; e_w = m_w; e_h = m_h;
      m_clr = !m_arm; m_arm = !m_arm;
    end else if (m_clr) begin
      m_arm = wr_arm; m_clr = 0;
    end else m_arm = m_arm | wr_arm;
    chk(fs === hit, "R8 fetch_start", 32'(fs), 32'(hit));
    chk(fc === ld, "R8 fifo_clr", 32'(fc), 32'(ld));
    chk(a_en === e_en && a_base === e_base && a_w === e_w && a_h === e_h,
        tag, a_base, e_base);
    if (ra == 2'd0) chk(rd[12] === m_arm, "R3 arm readback", 32'(rd[12]), 32'(m_arm));
  endtask

  task automatic idle_wr(input logic [1:0] i_wa, input logic [31:0] i_wd);
    tick(0, 0, 0, 0, 0, 1, i_wa, i_wd, "R11 idle");
  endtask

  // 10 lines of 4 cycles: 2 active, 2 front porch, 2 sync, 4 back porch
  task automatic run_frame(input int wr_t, input logic [1:0] i_wa, input logic [31:0] i_wd,
                           input string tag);
    int t = 0;
    int bp_last;
    bp_last = 6 + ((m_vbp <= 1) ? 0 : int'(m_vbp) - 1);
    for (int l = 0; l < 10; l++) begin
      for (int c = 0; c < 4; c++) begin
        logic act, h, w;
        act = (l < 2);
        case (m_opt)
          2'd0: h = (l == 1 && c == 3);
          2'd1: h = (l == 4 && c == 0);
          2'd2: h = (l == 6 && c == 0);
          default: h = (l == bp_last && c == 0);
        endcase
        w = (t == wr_t) || (wr_t == -2 && h);
        tick(act && (c == 1 || c == 2), !act || (l == 1 && c == 3), (l == 4 || l == 5),
             (c == 0), h, w, i_wa, i_wd, tag);
        t++;
      end
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(a_en === 0 && a_base === 0 && a_w === 0 && a_h === 0, "R1 active reset", a_base, 0);
    chk(fs === 0 && fc === 0 && rd[12] === 0, "R1 pulses/arm reset", {fs, fc, rd[12]}, 0);
    @(negedge clk); rst_n = 1;

    // R2 pending write/readback per register
    idle_wr(2'd1, 32'hA5A5_0001);
    idle_wr(2'd2, 32'h0438_0780);
    idle_wr(2'd3, 32'h0000_0003);
    idle_wr(2'd0, 32'h0000_0201);
    for (int a = 0; a < 4; a++) begin
      logic [31:0] exp;
      case (a)
        0: exp = 32'h0000_0201;
        1: exp = 32'hA5A5_0001;
        2: exp = 32'h0438_0780;
        default: exp = 32'h3;
      endcase
      @(negedge clk); ra = 2'(a); #1;
      chk(rd === exp, "R2 readback", rd, exp);
      chk(a_en === 0 && a_base === 0, "R2 active untouched", a_base, 0);
    end
    @(negedge clk); ra = 2'd0;

    // sweep load points x back porch lengths
    for (int o = 0; o < 4; o++) begin
      for (int v = 1; v <= 4; v++) begin
        int s = o * 4 + v;
        idle_wr(2'd3, 32'(v));
        idle_wr(2'd0, 32'(o << 8) | 32'(s & 1));
        idle_wr(2'd2, {16'(s * 3), 16'(s * 7)});
        idle_wr(2'd1, 32'h1000_0000 + 32'(s));
        run_frame(-1, 0, 0, "R11 unarmed frame");
        idle_wr(2'd0, 32'(o << 8) | 32'(~s & 1) | 32'h1000);
        idle_wr(2'd0, 32'(o << 8) | 32'(~s & 1));  // R3 write of 0 keeps arm
        run_frame(1, 2'd1, 32'h2000_0000 + 32'(s), pt_tag[o]);
        chk(a_base === 32'h2000_0000 + 32'(s), "R10 write while armed",
            a_base, 32'h2000_0000 + 32'(s));
        chk(rd[12] === 0, pt_tag[o], 32'(rd[12]), 0);
      end
    end

    // R9 arm in the load-point cycle, R10 same-cycle values taken
    idle_wr(2'd0, 32'h0000_0000);
    run_frame(-2, 2'd0, 32'h0000_1001, "R9 same-cycle arm");
    chk(a_en === 1, "R9 same-cycle load", 32'(a_en), 1);
    chk(rd[12] === 0, "R9 arm cleared", 32'(rd[12]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule